// File: doc/BRIEF.md
# I2C Register-Port Slave

This block is the serial front end of a small register-mapped peripheral. It samples the two-wire bus lines with the system clock and removes short noise pulses from both. It finds START and STOP conditions and decodes a 7-bit slave address. The address is a fixed 4-bit prefix set by a parameter, followed by three strap inputs. On a match it acknowledges and moves bytes between the bus and a plain register port. The port has a pointer, a write strobe with data, and a read strobe with data.

In a write transaction, the first byte after the address is a command byte. Its low pointer bits select the target register. Every later data byte in that transaction goes to that register. The pointer is kept between transactions, so a read that follows returns the selected register again and again until a new command byte arrives.

The data line is open-drain. The block only produces a pull-low enable; the pad and pull-up sit outside. There is no clock stretching, no general call and no 10-bit addressing.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset the data line is released, the register pointer is 0, no strobe is active, and the slave waits for a START.
- R2: Bus activity that is not preceded by a START (SDA falling while SCL is high) is ignored: a matching address clocked without a START gets no acknowledge.
- R3: The address byte holds the 7-bit address in bits 7..1, sent MSB first: the ADDR_PREFIX parameter (default 4'b0100) in the upper four bits and then strap_i[2:0]. Only an exact match is acknowledged, by pulling SDA low for the whole ninth clock. A mismatch stays silent until the next START.
- R4: Bit 0 of the address byte selects the direction, with 1 meaning read and 0 meaning write.
- R5: The first byte after a write address is acknowledged and its low PTR_W bits (bits 1..0 by default) become the register pointer. The upper bits are ignored.
- R6: Each following byte in a write transaction is acknowledged and produces one reg_wr_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte (MSB first on the bus). The pointer does not advance.
- R7: Data bytes written while the pointer is 0 are acknowledged but produce no write strobe.
- R8: In a read, the slave sends reg_rdata_i MSB first and then releases SDA for the master's acknowledge. On an acknowledge it reads the same register again and sends it. On a not-acknowledge it stops driving until the next START or STOP.
- R9: The pointer persists across transactions. A read with no command byte returns the register last selected.
- R10: A repeated START aborts any partial byte, produces no strobe, keeps the pointer, and restarts address reception.
- R11: Pulses on SCL or SDA that last fewer than FILT_LEN system clocks (default 4) are rejected.
- R12: The slave changes its SDA drive only while SCL is low, so the line is stable during every SCL high phase.
- R13: A STOP (SDA rising while SCL is high) returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| strap_i | input | 3 | Hardwired low address bits |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr_o | output | PTR_W | Register pointer |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, sampled in the reg_rd_o cycle |

## Verification
The address decode is swept over all 128 addresses with a fixed strap, and then over all eight strap values with a fixed address. This separates prefix errors, strap errors and bit-order errors. Write transactions use several pointers, including pointer 0 and command bytes with their upper bits set. Read transactions mix acknowledges and a not-acknowledge, which shows whether the pointer persists, whether the same register is re-read, and whether the line is released after the not-acknowledge. Repeated STARTs inside command and data bytes, bus activity with no START, and sub-threshold pulses on either line check that aborts, idle handling and the noise filter leave the pointer and the registers unchanged.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int BCNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_WSTOP
  } slv_state_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int   FILT_LEN = 4,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      flt_q  <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != flt_q) begin
        if (cnt_q == CNT_MAX) begin
          flt_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign flt_o = flt_q;

  // output only ever moves to the value the synchronizer has been presenting
  a_r11_filter_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flt_q) |-> flt_q == $past(sync_q[1]));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0100,
  parameter int         PTR_W       = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic [BYTE_W-1:0]   rdata_i,
  output logic                sda_pull_o,
  output logic [PTR_W-1:0]    addr_o,
  output logic                we_o,
  output logic [BYTE_W-1:0]   wdata_o,
  output logic                re_o
);
  localparam logic [BCNT_W-1:0] BITS_FULL = BCNT_W'(BYTE_W);
  localparam logic [BCNT_W-1:0] BITS_LAST = BCNT_W'(BYTE_W - 1);

  slv_state_e        state_q;
  logic [BCNT_W-1:0] bit_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              rw_q, mack_q, drive_q;
  logic [PTR_W-1:0]  ptr_q;

  logic byte_done, addr_hit, bus_evt, load_rd;

  assign byte_done = (bit_q == BITS_FULL);
  assign addr_hit  = (shreg_q[BYTE_W-1:1] == {ADDR_PREFIX, strap_i});
  assign bus_evt   = start_i | stop_i;
  assign load_rd   = ~bus_evt & scl_fall_i &
                     (((state_q == ST_AACK) & rw_q) | ((state_q == ST_RACK) & mack_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shreg_q <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
      ptr_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      bit_q   <= '0;
      drive_q <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WDAT: begin
          if (scl_rise_i && !byte_done) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
            bit_q   <= bit_q + 1'b1;
          end else if (scl_fall_i && byte_done) begin
            bit_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_q <= ST_AACK;
                rw_q    <= shreg_q[0];
                drive_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_CMD) begin
              ptr_q   <= shreg_q[PTR_W-1:0];
              state_q <= ST_CACK;
              drive_q <= 1'b1;
            end else begin
              state_q <= ST_WACK;
              drive_q <= 1'b1;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            bit_q <= '0;
            if (rw_q) begin
              state_q <= ST_RDAT;
              shreg_q <= rdata_i;
              drive_q <= ~rdata_i[BYTE_W-1];
            end else begin
              state_q <= ST_CMD;
              drive_q <= 1'b0;
            end
          end
        end
        ST_CACK, ST_WACK: begin
          if (scl_fall_i) begin
            state_q <= ST_WDAT;
            bit_q   <= '0;
            drive_q <= 1'b0;
          end
        end
        ST_RDAT: begin
          if (scl_fall_i) begin
            if (bit_q == BITS_LAST) begin
              state_q <= ST_RACK;
              drive_q <= 1'b0;
            end else begin
              bit_q   <= bit_q + 1'b1;
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              drive_q <= ~shreg_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            bit_q <= '0;
            if (mack_q) begin
              state_q <= ST_RDAT;
              shreg_q <= rdata_i;
              drive_q <= ~rdata_i[BYTE_W-1];
            end else begin
              state_q <= ST_WSTOP;
              drive_q <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = drive_q;
  assign addr_o     = ptr_q;
  assign wdata_o    = shreg_q;
  assign we_o       = ~bus_evt & scl_fall_i & byte_done & (state_q == ST_WDAT) & (ptr_q != '0);
  assign re_o       = load_rd;

  // R12: drive moves only while the filtered clock is low
  a_r12_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(drive_q) && !$past(start_i) && !$past(stop_i)) |-> !scl_i);
  a_r13_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == ST_IDLE);
  a_r10_start_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR) && $stable(ptr_q));
  a_r6_write_then_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> state_q == ST_WACK);
  a_r8_read_then_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> state_q == ST_RDAT);
  a_r6_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_o, re_o}));
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0100,
  parameter int         FILT_LEN    = 4,
  parameter int         PTR_W       = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  output logic               sda_pull_o,
  output logic [PTR_W-1:0]   reg_addr_o,
  output logic               reg_wr_o,
  output logic [7:0]         reg_wdata_o,
  output logic               reg_rd_o,
  input  logic [7:0]         reg_rdata_i
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_glitch_filter #(
      .FILT_LEN (FILT_LEN),
      .RST_VAL  (1'b1)
    ) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_lines[g]),
      .flt_o  (flt_lines[g])
    );
  end

  i2c_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (flt_lines[0]),
    .sda_i      (flt_lines[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slv_engine #(
    .ADDR_PREFIX (ADDR_PREFIX),
    .PTR_W       (PTR_W)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (flt_lines[0]),
    .sda_i      (flt_lines[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .strap_i    (strap_i),
    .rdata_i    (reg_rdata_i),
    .sda_pull_o (sda_pull_o),
    .addr_o     (reg_addr_o),
    .we_o       (reg_wr_o),
    .wdata_o    (reg_wdata_o),
    .re_o       (reg_rd_o)
  );
endmodule

// File: tb/i2c_regport_slave_test.sv
module i2c_regport_slave_test;
  localparam int         Q   = 12;
  localparam logic [3:0] PFX = 4'b0100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_pull, reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [4];
  int wr_cnt, rd_cnt, stab_err;
  int vecs = 0, fails = 0;
  bit done = 0;
  wire sda_line = sda_m & ~sda_pull;

  always #2 clk_i = ~clk_i;

  i2c_regport_slave uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull), .reg_addr_o(reg_addr),
    .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata));

  // peripheral model: reg 0 is a fixed input value
  assign reg_rdata = regs[reg_addr];
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs[0] <= 8'hC3; regs[1] <= 8'h00; regs[2] <= 8'h00; regs[3] <= 8'h00;
      wr_cnt <= 0; rd_cnt <= 0;
    end else begin
      if (reg_wr) begin
        wr_cnt <= wr_cnt + 1;
        if (reg_addr != 2'd0) regs[reg_addr] <= reg_wdata;
      end
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk_i); endtask

  task automatic do_start();
    hq(); sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    hq(); sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    hq(); sda_m = b;
    if (glitch) begin
      repeat (4) @(negedge clk_i); scl_m = 1'b1;
      repeat (3) @(negedge clk_i); scl_m = 1'b0;
      repeat (Q - 7) @(negedge clk_i);
    end else hq();
    scl_m = 1'b1; hq(); hq(); scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack, input int gbit = -1);
    logic s1;
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == gbit);
    hq(); sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); s1 = sda_line; hq();
    if (s1 != sda_line) stab_err++;
    scl_m = 1'b0;
    ack = !s1;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    logic s1;
    for (int i = 0; i < 8; i++) begin
      hq(); sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); s1 = sda_line; hq();
      if (s1 != sda_line) stab_err++;
      scl_m = 1'b0;
      d = {d[6:0], s1};
    end
    hq(); sda_m = !mack; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0;
  endtask

  task automatic part_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) send_bit(b[7-i], 1'b0);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    logic [7:0] aw, ar;
    int wc;
    aw = {PFX, 3'b101, 1'b0};
    ar = {PFX, 3'b101, 1'b1};
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(sda_pull == 1'b0, "R1 pull", sda_pull, 0);
    check(reg_addr == 2'd0, "R1 ptr", reg_addr, 0);
    check(!reg_wr && !reg_rd, "R1 strobes", {reg_wr, reg_rd}, 0);

    // R2: matching address without START
    hq(); scl_m = 1'b0;
    write_byte(aw, ack);
    check(!ack, "R2 no start", ack, 0);
    do_stop();

    // R11: short SDA pulse while SCL high is not a START
    sda_m = 1'b0; repeat (3) @(negedge clk_i); sda_m = 1'b1;
    hq(); scl_m = 1'b0;
    write_byte(aw, ack);
    check(!ack, "R11 sda glitch", ack, 0);
    do_stop();

    // R3: sweep all addresses with fixed strap
    for (int a = 0; a < 128; a++) begin
      do_start();
      write_byte({a[6:0], 1'b0}, ack);
      check(ack == (a[6:0] == {PFX, 3'b101}), "R3 addr sweep", ack, a);
      do_stop();
    end
    // R3: sweep strap with fixed address
    for (int s = 0; s < 8; s++) begin
      strap = s[2:0];
      do_start();
      write_byte({PFX, 3'b011, 1'b0}, ack);
      check(ack == (s == 3), "R3 strap sweep", ack, s);
      do_stop();
    end
    strap = 3'b101;

    // R5/R6: write two bytes to register 1
    do_start();
    write_byte(aw, ack); check(ack, "R3 addr ack", ack, 1);
    write_byte(8'h01, ack); check(ack, "R5 cmd ack", ack, 1);
    write_byte(8'hA5, ack); check(ack, "R6 data ack", ack, 1);
    write_byte(8'h3C, ack); check(ack, "R6 data ack", ack, 1);
    do_stop();
    check(regs[1] == 8'h3C, "R6 reg1", regs[1], 8'h3C);
    check(wr_cnt == 2, "R6 write count", wr_cnt, 2);

    // R5: upper command bits ignored
    do_start();
    write_byte(aw, ack);
    write_byte(8'hFE, ack);
    write_byte(8'h5A, ack);
    do_stop();
    check(regs[2] == 8'h5A, "R5 low bits ptr", regs[2], 8'h5A);

    // R7: register 0 writes acked, dropped
    do_start();
    write_byte(aw, ack);
    write_byte(8'h00, ack);
    write_byte(8'h77, ack); check(ack, "R7 ack", ack, 1);
    do_stop();
    check(wr_cnt == 3, "R7 no strobe", wr_cnt, 3);

    // R8/R4: read same register repeatedly
    do_start();
    write_byte(aw, ack);
    write_byte(8'h03, ack);
    write_byte(8'h96, ack);
    do_stop();
    do_start();
    write_byte(ar, ack); check(ack, "R4 read addr ack", ack, 1);
    read_byte(1'b1, d); check(d == 8'h96, "R8 byte1", d, 8'h96);
    read_byte(1'b1, d); check(d == 8'h96, "R8 byte2", d, 8'h96);
    read_byte(1'b0, d); check(d == 8'h96, "R8 byte3", d, 8'h96);
    read_byte(1'b0, d); check(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    do_stop();
    check(rd_cnt == 3, "R8 read count", rd_cnt, 3);

    // R13: after STOP an unprefixed address is ignored
    hq(); scl_m = 1'b0;
    write_byte(aw, ack);
    check(!ack, "R13 idle after stop", ack, 0);
    do_stop();

    // R9: pointer persists
    do_start();
    write_byte(ar, ack);
    read_byte(1'b0, d); check(d == 8'h96, "R9 persist", d, 8'h96);
    do_stop();
    do_start();
    write_byte(aw, ack);
    write_byte(8'h00, ack);
    do_stop();
    do_start();
    write_byte(ar, ack);
    read_byte(1'b0, d); check(d == 8'hC3, "R9 reg0 read", d, 8'hC3);
    do_stop();

    // R10: repeated START inside command byte keeps pointer
    do_start();
    write_byte(aw, ack);
    write_byte(8'h02, ack);
    do_stop();
    do_start();
    write_byte(aw, ack);
    part_bits(8'h01, 4);
    do_start();
    write_byte(ar, ack); check(ack, "R10 restart ack", ack, 1);
    read_byte(1'b0, d); check(d == 8'h5A, "R10 ptr kept", d, 8'h5A);
    do_stop();
    // R10: abort inside data byte
    wc = wr_cnt;
    do_start();
    write_byte(aw, ack);
    write_byte(8'h03, ack);
    part_bits(8'h11, 5);
    do_start();
    write_byte(aw, ack); check(ack, "R10 restart ack w", ack, 1);
    do_stop();
    check(wr_cnt == wc, "R10 no strobe", wr_cnt, wc);
    check(regs[3] == 8'h96, "R10 reg3 kept", regs[3], 8'h96);

    // R11: short SCL pulse inside a data byte
    do_start();
    write_byte(aw, ack);
    write_byte(8'h01, ack);
    write_byte(8'h6D, ack, 3);
    check(ack, "R11 glitch byte ack", ack, 1);
    do_stop();
    check(regs[1] == 8'h6D, "R11 scl glitch", regs[1], 8'h6D);

    // R12: slave data stable while SCL high
    check(stab_err == 0, "R12 stability", stab_err, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      vecs++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule